// File: doc/BRIEF.md
# Operand Addressing Mode Decoder

This block turns the 6-bit operand field of a 16-bit processor instruction into a concrete operand. The operand can be one of the eight general registers, a memory word addressed by a register, a memory word at an extension word plus a register, a stack slot, the stack pointer, the program counter or the overflow register, or an immediate constant. The caller supplies the field, the flattened register file, the current SP, PC and overflow values, and the word stored at PC, which is the extension word. The block issues a memory read address in the same cycle. One cycle later it presents the operand value, the kind and address of the write target, an extension-word consume flag, the next PC and the next SP.

When an instruction has two operands, the caller decodes the A field first. The caller then decodes the B field using the PC returned by the first decode, so any extension word for A comes from the lower address. In skip mode the instruction is being stepped over. The block still advances PC past its extension words but leaves the stack and memory alone. Writes aimed at literal operands are dropped by reporting no write target.

Top module: `operand_decoder`

## Requirements
- R1: Field values 0 to 7 select general register (field & 7). rdValue is that register, wrKind is 1 (general register) and wrAddr is the register index. Register i sits at regFile bits [16*i+15 : 16*i].
- R2: Field values 8 to 15 assert memRdEn with memRdAddr equal to register (field & 7) in the decode cycle. In the result cycle, rdValue is the memory data, wrKind is 2 (memory) and wrAddr is that address.
- R3: Field values 16 to 23 address memory at extWord + register (field & 7), truncated to 16 bits. The decode sets extUsed and returns pcNext = pcIn + 1.
- R4: Field 24 (pop) reads memory at spIn and returns spNext = spIn + 1. Field 25 (peek) reads memory at spIn and leaves SP unchanged. Field 26 (push) reads memory at spIn - 1 and returns spNext = spIn - 1. spWe is high only for pop and push. In every other case spNext equals spIn. All SP arithmetic wraps at 16 bits.
- R5: Fields 27, 28 and 29 read spIn, pcIn and ovfIn. They give wrKind 3, 4 and 5 respectively, with wrAddr 0.
- R6: Field 30 consumes the extension word and addresses memory at extWord, with wrKind 2.
- R7: Field 31 returns extWord as the value, consumes it, and gives wrKind 0 (write dropped).
- R8: Field values 32 to 63 return the constant (field - 32), give wrKind 0 and consume no extension word.
- R9: extUsed is high, and pcNext is pcIn + 1, exactly for fields 16 to 23, 30 and 31. Otherwise extUsed is low and pcNext equals pcIn. Each extUsed pulse marks one extra instruction cycle.
- R10: With skipMode high, extension-word consumption and pcNext follow R9. memRdEn is low, spWe is low, spNext equals spIn, wrKind is 0 and rdValue is 0.
- R11: While decValid is low, memRdEn is low. After reset, resValid, spWe, extUsed and wrKind are 0 until a decode is accepted.
- R12: Results appear on the clock edge after decValid, with resValid high for exactly that cycle. A cycle without decValid gives resValid 0, spWe 0, extUsed 0 and wrKind 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| decValid | input | 1 | Decode the field this cycle |
| skipMode | input | 1 | Instruction is being skipped |
| opField | input | 6 | Operand field |
| regFile | input | 128 | Eight 16-bit general registers, register i at [16*i +: 16] |
| spIn | input | 16 | Current stack pointer |
| pcIn | input | 16 | Current program counter (address of a possible extension word) |
| ovfIn | input | 16 | Current overflow register |
| extWord | input | 16 | Memory word at pcIn |
| memRdData | input | 16 | Synchronous read data for the address issued the cycle before |
| memRdEn | output | 1 | Memory read request (decode cycle) |
| memRdAddr | output | 16 | Memory read address (decode cycle) |
| resValid | output | 1 | Result fields valid |
| rdValue | output | 16 | Operand value |
| wrKind | output | 3 | Write target: 0 none, 1 register, 2 memory, 3 SP, 4 PC, 5 overflow |
| wrAddr | output | 16 | Register index or memory address of the write target |
| extUsed | output | 1 | Extension word consumed (one extra cycle) |
| pcNext | output | 16 | PC after this operand |
| spNext | output | 16 | SP after this operand |
| spWe | output | 1 | SP changes to spNext |

## Verification
The bench walks all 64 field values, both with and without skip, and then runs random register, SP, PC and extension-word contents. The directed cases go after three wrap-around points. An indexed address that overflows past 0xFFFF would land above 16 bits if it were not truncated. A push from SP 0 must give 0xFFFF. A pop at 0xFFFF must give 0. The field 31 boundary is checked separately: a decoder that treated 31 as a memory or register target would leak a write to a literal. A decoder that ignored skip for extension fields would leave PC pointing into the skipped instruction's operands. A decoder that ignored skip for stack fields would corrupt SP. An idle cycle after a pop would expose a stale SP strobe that applies the pop twice.

// File: rtl/opdec_pkg.sv
package opdec_pkg;
  localparam int FIELD_W   = 6;
  localparam int REG_IDX_W = 3;
  localparam int REG_N     = 1 << REG_IDX_W;
  localparam int LIT_W     = FIELD_W - 1;

  typedef enum logic [2:0] {
    WK_NONE = 3'd0,
    WK_GPR  = 3'd1,
    WK_MEM  = 3'd2,
    WK_SP   = 3'd3,
    WK_PC   = 3'd4,
    WK_OVF  = 3'd5
  } wrKind_e;

  typedef enum logic [2:0] {
    SRC_ZERO, SRC_GPR, SRC_MEM, SRC_SP, SRC_PC, SRC_OVF, SRC_EXT, SRC_LIT
  } srcSel_e;

  typedef enum logic [2:0] {
    AD_REG, AD_EXTREG, AD_SP, AD_SPDEC, AD_EXT
  } addrSel_e;

  typedef struct packed {
    srcSel_e              src;
    wrKind_e              wrKind;
    addrSel_e             addrSel;
    logic                 useExt;
    logic                 memRd;
    logic                 spInc;
    logic                 spDec;
    logic [REG_IDX_W-1:0] regIdx;
    logic [LIT_W-1:0]     litVal;
  } ctrl_t;
endpackage

// File: rtl/opdec_ctrl.sv
module opdec_ctrl
  import opdec_pkg::*;
(
  input  logic               decValid,
  input  logic               skipMode,
  input  logic [FIELD_W-1:0] opField,
  output ctrl_t              ctrl
);
  ctrl_t raw;

  always_comb begin
    raw         = '0;
    raw.src     = SRC_ZERO;
    raw.wrKind  = WK_NONE;
    raw.addrSel = AD_REG;
    raw.regIdx  = opField[REG_IDX_W-1:0];
    raw.litVal  = opField[LIT_W-1:0];
    if (opField[FIELD_W-1]) begin
      raw.src = SRC_LIT;
    end else begin
      case (opField[4:3])
        2'b00: begin
          raw.src    = SRC_GPR;
          raw.wrKind = WK_GPR;
        end
        2'b01: begin
          raw.src    = SRC_MEM;
          raw.memRd  = 1'b1;
          raw.wrKind = WK_MEM;
        end
        2'b10: begin
          raw.src     = SRC_MEM;
          raw.memRd   = 1'b1;
          raw.wrKind  = WK_MEM;
          raw.addrSel = AD_EXTREG;
          raw.useExt  = 1'b1;
        end
        default: begin
          case (opField[2:0])
            3'd0: begin
              raw.src = SRC_MEM; raw.memRd = 1'b1; raw.wrKind = WK_MEM;
              raw.addrSel = AD_SP; raw.spInc = 1'b1;
            end
            3'd1: begin
              raw.src = SRC_MEM; raw.memRd = 1'b1; raw.wrKind = WK_MEM;
              raw.addrSel = AD_SP;
            end
            3'd2: begin
              raw.src = SRC_MEM; raw.memRd = 1'b1; raw.wrKind = WK_MEM;
              raw.addrSel = AD_SPDEC; raw.spDec = 1'b1;
            end
            3'd3: begin raw.src = SRC_SP;  raw.wrKind = WK_SP;  end
            3'd4: begin raw.src = SRC_PC;  raw.wrKind = WK_PC;  end
            3'd5: begin raw.src = SRC_OVF; raw.wrKind = WK_OVF; end
            3'd6: begin
              raw.src = SRC_MEM; raw.memRd = 1'b1; raw.wrKind = WK_MEM;
              raw.addrSel = AD_EXT; raw.useExt = 1'b1;
            end
            default: begin
              raw.src = SRC_EXT; raw.useExt = 1'b1;
            end
          endcase
        end
      endcase
    end
  end

  // Skip keeps only the extension-word consumption; idle blocks all strobes.
  always_comb begin
    ctrl = raw;
    if (skipMode) begin
      ctrl.src    = SRC_ZERO;
      ctrl.wrKind = WK_NONE;
      ctrl.memRd  = 1'b0;
      ctrl.spInc  = 1'b0;
      ctrl.spDec  = 1'b0;
    end
    if (!decValid) begin
      ctrl.memRd = 1'b0;
      ctrl.spInc = 1'b0;
      ctrl.spDec = 1'b0;
    end
  end
endmodule

// File: rtl/opdec_dpath.sv
module opdec_dpath
  import opdec_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    decValid,
  input  ctrl_t                   ctrl,
  input  logic [REG_N*WORD_W-1:0] regFile,
  input  logic [WORD_W-1:0]       spIn,
  input  logic [WORD_W-1:0]       pcIn,
  input  logic [WORD_W-1:0]       ovfIn,
  input  logic [WORD_W-1:0]       extWord,
  input  logic [WORD_W-1:0]       memRdData,
  output logic                    memRdEn,
  output logic [WORD_W-1:0]       memRdAddr,
  output logic                    resValid,
  output logic [WORD_W-1:0]       rdValue,
  output logic [2:0]              wrKind,
  output logic [WORD_W-1:0]       wrAddr,
  output logic                    extUsed,
  output logic [WORD_W-1:0]       pcNext,
  output logic [WORD_W-1:0]       spNext,
  output logic                    spWe
);
  logic [WORD_W-1:0] regArr [REG_N];

  for (genvar g = 0; g < REG_N; g++) begin : g_unpack
    assign regArr[g] = regFile[g*WORD_W +: WORD_W];
  end

  logic [WORD_W-1:0] selReg, spDecd, addr, holdNext, wrAddrNext;

  assign selReg = regArr[ctrl.regIdx];
  assign spDecd = spIn - WORD_W'(1);

  always_comb begin
    case (ctrl.addrSel)
      AD_EXTREG: addr = extWord + selReg;
      AD_SP:     addr = spIn;
      AD_SPDEC:  addr = spDecd;
      AD_EXT:    addr = extWord;
      default:   addr = selReg;
    endcase
  end

  always_comb begin
    case (ctrl.src)
      SRC_GPR: holdNext = selReg;
      SRC_SP:  holdNext = spIn;
      SRC_PC:  holdNext = pcIn;
      SRC_OVF: holdNext = ovfIn;
      SRC_EXT: holdNext = extWord;
      SRC_LIT: holdNext = WORD_W'(ctrl.litVal);
      default: holdNext = '0;
    endcase
  end

  always_comb begin
    case (ctrl.wrKind)
      WK_GPR:  wrAddrNext = WORD_W'(ctrl.regIdx);
      WK_MEM:  wrAddrNext = addr;
      default: wrAddrNext = '0;
    endcase
  end

  assign memRdEn   = ctrl.memRd;
  assign memRdAddr = addr;

  logic              isMemQ;
  logic [WORD_W-1:0] holdQ;
  logic [2:0]        wrKindQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid <= 1'b0;
      isMemQ   <= 1'b0;
      holdQ    <= '0;
      wrKindQ  <= '0;
      wrAddr   <= '0;
      extUsed  <= 1'b0;
      pcNext   <= '0;
      spNext   <= '0;
      spWe     <= 1'b0;
    end else begin
      resValid <= decValid;
      if (decValid) begin
        isMemQ  <= (ctrl.src == SRC_MEM);
        holdQ   <= holdNext;
        wrKindQ <= ctrl.wrKind;
        wrAddr  <= wrAddrNext;
        extUsed <= ctrl.useExt;
        pcNext  <= pcIn + WORD_W'(ctrl.useExt);
        spWe    <= ctrl.spInc | ctrl.spDec;
        spNext  <= ctrl.spInc ? spIn + WORD_W'(1) : (ctrl.spDec ? spDecd : spIn);
      end else begin
        wrKindQ <= '0;
        extUsed <= 1'b0;
        spWe    <= 1'b0;
      end
    end
  end

  assign wrKind  = wrKindQ;
  assign rdValue = isMemQ ? memRdData : holdQ;
endmodule

// File: rtl/operand_decoder.sv
module operand_decoder
  import opdec_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    decValid,
  input  logic                    skipMode,
  input  logic [FIELD_W-1:0]      opField,
  input  logic [REG_N*WORD_W-1:0] regFile,
  input  logic [WORD_W-1:0]       spIn,
  input  logic [WORD_W-1:0]       pcIn,
  input  logic [WORD_W-1:0]       ovfIn,
  input  logic [WORD_W-1:0]       extWord,
  input  logic [WORD_W-1:0]       memRdData,
  output logic                    memRdEn,
  output logic [WORD_W-1:0]       memRdAddr,
  output logic                    resValid,
  output logic [WORD_W-1:0]       rdValue,
  output logic [2:0]              wrKind,
  output logic [WORD_W-1:0]       wrAddr,
  output logic                    extUsed,
  output logic [WORD_W-1:0]       pcNext,
  output logic [WORD_W-1:0]       spNext,
  output logic                    spWe
);
  ctrl_t ctrl;

  opdec_ctrl i_ctrl (
    .decValid (decValid),
    .skipMode (skipMode),
    .opField  (opField),
    .ctrl     (ctrl)
  );

  opdec_dpath #(.WORD_W(WORD_W)) i_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .decValid  (decValid),
    .ctrl      (ctrl),
    .regFile   (regFile),
    .spIn      (spIn),
    .pcIn      (pcIn),
    .ovfIn     (ovfIn),
    .extWord   (extWord),
    .memRdData (memRdData),
    .memRdEn   (memRdEn),
    .memRdAddr (memRdAddr),
    .resValid  (resValid),
    .rdValue   (rdValue),
    .wrKind    (wrKind),
    .wrAddr    (wrAddr),
    .extUsed   (extUsed),
    .pcNext    (pcNext),
    .spNext    (spNext),
    .spWe      (spWe)
  );
endmodule

// File: rtl/opdec_checker.sv
module opdec_checker #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              decValid,
  input logic              skipMode,
  input logic [5:0]        opField,
  input logic [WORD_W-1:0] spIn,
  input logic [WORD_W-1:0] pcIn,
  input logic              memRdEn,
  input logic [WORD_W-1:0] memRdAddr,
  input logic              resValid,
  input logic [2:0]        wrKind,
  input logic              extUsed,
  input logic [WORD_W-1:0] pcNext,
  input logic [WORD_W-1:0] spNext,
  input logic              spWe
);
  logic isExtCode;
  assign isExtCode = (opField[5:3] == 3'b010) || (opField == 6'h1e) || (opField == 6'h1f);

  // R7 and R8: literal targets never produce a write
  p_lit_drop_r8: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && opField >= 6'h1f) |=> (wrKind == 3'd0));

  p_ext_pc_r9: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && isExtCode) |=> (extUsed && pcNext == $past(pcIn) + WORD_W'(1)));

  p_noext_pc_r9: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && !isExtCode) |=> (!extUsed && pcNext == $past(pcIn)));

  p_skip_nomem_r10: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && skipMode) |-> !memRdEn);

  p_skip_nosp_r10: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && skipMode) |=> (!spWe && wrKind == 3'd0));

  p_pop_sp_r4: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && !skipMode && opField == 6'h18) |=> (spWe && spNext == $past(spIn) + WORD_W'(1)));

  p_push_addr_r4: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && !skipMode && opField == 6'h1a) |-> (memRdEn && memRdAddr == spIn - WORD_W'(1)));

  p_idle_nomem_r11: assert property (@(posedge clk) disable iff (!rstN)
    !decValid |-> !memRdEn);

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rstN)
    !decValid |=> (!resValid && !spWe && !extUsed));
endmodule

bind operand_decoder opdec_checker #(.WORD_W(WORD_W)) i_opdecChecker (
  .clk       (clk),
  .rstN      (rstN),
  .decValid  (decValid),
  .skipMode  (skipMode),
  .opField   (opField),
  .spIn      (spIn),
  .pcIn      (pcIn),
  .memRdEn   (memRdEn),
  .memRdAddr (memRdAddr),
  .resValid  (resValid),
  .wrKind    (wrKind),
  .extUsed   (extUsed),
  .pcNext    (pcNext),
  .spNext    (spNext),
  .spWe      (spWe)
);

// File: tb/test_operand_decoder.sv
`timescale 1ns/1ps
module test_operand_decoder;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         decValid = 1'b0;
  logic         skipMode = 1'b0;
  logic [5:0]   opField = '0;
  logic [127:0] regFile = '0;
  logic [15:0]  spIn = '0, pcIn = '0, ovfIn = '0, extWord = '0;
  logic [15:0]  memRdData = '0;
  logic         memRdEn, resValid, extUsed, spWe;
  logic [15:0]  memRdAddr, rdValue, wrAddr, pcNext, spNext;
  logic [2:0]   wrKind;

  int total = 0;
  int bad = 0;
  bit doneFlag = 0;

  always #10 clk = ~clk;

  operand_decoder i_operand_decoder (
    .clk(clk), .rstN(rstN), .decValid(decValid), .skipMode(skipMode),
    .opField(opField), .regFile(regFile), .spIn(spIn), .pcIn(pcIn),
    .ovfIn(ovfIn), .extWord(extWord), .memRdData(memRdData),
    .memRdEn(memRdEn), .memRdAddr(memRdAddr), .resValid(resValid),
    .rdValue(rdValue), .wrKind(wrKind), .wrAddr(wrAddr), .extUsed(extUsed),
    .pcNext(pcNext), .spNext(spNext), .spWe(spWe)
  );

  function automatic logic [15:0] memFn(input logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'hA55A;
  endfunction

  // synchronous memory model
  always @(posedge clk) memRdData <= memFn(memRdAddr);

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic string tagOf(input int code, input bit skip);
    if (skip) return "R10";
    if (code < 8)   return "R1";
    if (code < 16)  return "R2";
    if (code < 24)  return "R3";
    if (code < 27)  return "R4";
    if (code < 30)  return "R5";
    if (code == 30) return "R6";
    if (code == 31) return "R7";
    return "R8";
  endfunction

  task automatic runOne(input int code, input bit skip, input logic [15:0] sp,
                        input logic [15:0] pc, input logic [15:0] ext);
    logic [15:0] r [8];
    logic [15:0] ovf, addr, expRd, expWa, expSp;
    logic [2:0]  expWk;
    bit isExt, expEn, expSpWe;
    int idx;
    string tg;
    for (int i = 0; i < 8; i++) r[i] = 16'($urandom);
    ovf = 16'($urandom);
    idx = code % 8;
    tg = tagOf(code, skip);
    isExt = (code >= 16 && code < 24) || code == 30 || code == 31;
    expEn = 0; expSpWe = 0; expSp = sp; expWk = 0; expWa = 0; expRd = 0; addr = 0;
    if (!skip) begin
      if (code < 8) begin expWk = 1; expWa = 16'(idx); expRd = r[idx]; end
      else if (code < 16) begin expEn = 1; addr = r[idx]; end
      else if (code < 24) begin expEn = 1; addr = ext + r[idx]; end
      else if (code == 24) begin expEn = 1; addr = sp; expSp = sp + 16'd1; expSpWe = 1; end
      else if (code == 25) begin expEn = 1; addr = sp; end
      else if (code == 26) begin expEn = 1; addr = sp - 16'd1; expSp = sp - 16'd1; expSpWe = 1; end
      else if (code == 27) begin expWk = 3; expRd = sp; end
      else if (code == 28) begin expWk = 4; expRd = pc; end
      else if (code == 29) begin expWk = 5; expRd = ovf; end
      else if (code == 30) begin expEn = 1; addr = ext; end
      else if (code == 31) begin expRd = ext; end
      else expRd = 16'(code - 32);
      if (expEn) begin expWk = 2; expWa = addr; expRd = memFn(addr); end
    end
    decValid = 1; skipMode = skip; opField = 6'(code);
    spIn = sp; pcIn = pc; extWord = ext; ovfIn = ovf;
    for (int i = 0; i < 8; i++) regFile[i*16 +: 16] = r[i];
    #1;
    chk(tg, "memRdEn", 16'(memRdEn), 16'(expEn));
    if (expEn) chk(tg, "memRdAddr", memRdAddr, addr);
    @(negedge clk);
    decValid = 0;
    chk("R12", "resValid", 16'(resValid), 16'd1);
    chk(tg, "rdValue", rdValue, expRd);
    chk(tg, "wrKind", 16'(wrKind), 16'(expWk));
    chk(tg, "wrAddr", wrAddr, expWa);
    chk(isExt ? "R9" : tg, "extUsed", 16'(extUsed), 16'(isExt));
    chk(isExt ? "R9" : tg, "pcNext", pcNext, isExt ? pc + 16'd1 : pc);
    chk(tg, "spWe", 16'(spWe), 16'(expSpWe));
    chk(tg, "spNext", spNext, expSp);
  endtask

  task automatic idleCheck(input string tg);
    decValid = 0;
    #1;
    chk(tg, "idle memRdEn", 16'(memRdEn), 16'd0);
    @(negedge clk);
    chk(tg, "idle resValid", 16'(resValid), 16'd0);
    chk(tg, "idle spWe", 16'(spWe), 16'd0);
    chk(tg, "idle extUsed", 16'(extUsed), 16'd0);
    chk(tg, "idle wrKind", 16'(wrKind), 16'd0);
  endtask

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11", "reset resValid", 16'(resValid), 16'd0);
    chk("R11", "reset spWe", 16'(spWe), 16'd0);
    chk("R11", "reset extUsed", 16'(extUsed), 16'd0);
    chk("R11", "reset wrKind", 16'(wrKind), 16'd0);
    rstN = 1;
    @(negedge clk);
    idleCheck("R11");
    // every field, normal and skipped
    for (int code = 0; code < 64; code++) begin
      runOne(code, 0, 16'($urandom), 16'($urandom), 16'($urandom));
      runOne(code, 1, 16'($urandom), 16'($urandom), 16'($urandom));
    end
    // R3: indexed address wraps at 16 bits (worst case: ext 0xFFFF)
    runOne(16'h12, 0, 16'h1000, 16'h0200, 16'hFFFF);
    // R4: push from SP 0 and pop at SP 0xFFFF wrap
    runOne(26, 0, 16'h0000, 16'h0010, 16'h1234);
    runOne(24, 0, 16'hFFFF, 16'h0010, 16'h1234);
    // R12: stale SP strobe must not repeat on an idle cycle after a pop
    idleCheck("R12");
    // R10: skipped push leaves SP at 0
    runOne(26, 1, 16'h0000, 16'hFFFF, 16'h0000);
    // random mix
    for (int n = 0; n < 400; n++) begin
      runOne(int'($urandom_range(63, 0)), bit'($urandom_range(3, 0) == 0),
             16'($urandom), 16'($urandom), 16'($urandom));
      if ($urandom_range(7, 0) == 0) idleCheck("R12");
    end
    finishRun();
  end
endmodule